// File: doc/BRIEF.md
# PLL Control and Lock Status Register

This block is the software-facing control word for one PLL. A single 32-bit register holds the four divider settings and a power-down request. Next to these it keeps a live lock indication and a sticky flag that records any loss of lock. The analog loop is not modelled. Instead, a reference-cycle counter stands in for the settling time, so the lock bit only comes back after a fixed number of cycles once the PLL is allowed to run again.

Software writes the whole word in one cycle and can read it back at any time. The read port returns the current state and has no latency. Downstream clock logic uses the lock output as the qualifier for the PLL clock: the nominal rate is ref × feedback ÷ (input × out1 × out2) while lock is high and zero while it is low. The divider outputs carry the values that are currently programmed.

Top module: `pll_ctrl_reg`

## Requirements
- R1: After reset, read data equals RESET_VAL with bit 31 (lock) forced to 1 and all reserved bits 0, and the lock output is 1. The default RESET_VAL of 32'h0030_2102 reads back as 32'h8030_2102.
- R2: The field positions are fixed. Feedback divider is bits [27:16], second output divider [15:13], power-down bit 12, first output divider [10:8], input divider [5:0]. Each field reads back as written. Reserved bits 29, 28, 11, 7 and 6 always read 0.
- R3: A write with bit 12 set makes lock (bit 31 and the lock output) 0 and sets loss-of-lock (bit 30) 1 from the next cycle on. Lock stays 0 for as long as power-down stays set.
- R4: A write that clears bit 12 while the PLL is powered down restarts the lock counter. Lock rises exactly LOCK_CYCLES clock edges after the write edge and not earlier.
- R5: A write that leaves bit 12 clear but changes any divider field restarts the counter. Lock drops on the next cycle and returns LOCK_CYCLES edges after the write. Loss-of-lock is not set by this.
- R6: A write that leaves bit 12 clear and repeats the current divider values does not disturb lock or a lock count already in progress.
- R7: Bit 30 is cleared only by a write with bit 30 = 1 and bit 12 = 0. A write of 0 to bit 30 leaves it unchanged. A write of 1 to bit 30 together with power-down leaves it set.
- R8: Bit 31 is read-only. The value written to it has no effect on lock.
- R9: The divider and power-down outputs show the programmed fields from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the whole word |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current register contents |
| lock_o | output | 1 | PLL locked; output clock valid |
| pwrdn_o | output | 1 | Power-down request to the PLL |
| fb_div_o | output | 12 | Feedback divider |
| out_div2_o | output | 3 | Second output divider |
| out_div1_o | output | 3 | First output divider |
| in_div_o | output | 6 | Input divider |

## Verification
Every field, the power-down bit and the loss-of-lock flag are registered once, so each of them is due one edge after the write edge. Lock is due exactly LOCK_CYCLES edges after the write that released or changed the PLL. The bench drives all inputs on falling edges and samples on falling edges. After a write it checks lock at edge LOCK_CYCLES−1, where it must still be low, and again at edge LOCK_CYCLES, where it must be high. The sweeps over the divider fields compare each read-back word one edge after its write.

// File: rtl/pllc_pkg.sv
package pllc_pkg;
   // Field positions are visible to software and to the read-back word.
   localparam int FB_LSB   = 16;
   localparam int FB_W     = 12;
   localparam int OD2_LSB  = 13;
   localparam int OD2_W    = 3;
   localparam int PD_BIT   = 12;
   localparam int OD1_LSB  = 8;
   localparam int OD1_W    = 3;
   localparam int IN_LSB   = 0;
   localparam int IN_W     = 6;
   localparam int LOST_BIT = 30;
   localparam int LOCK_BIT = 31;
   localparam int WORD_W   = 32;

   typedef struct packed {
      logic [FB_W-1:0]  fb;
      logic [OD2_W-1:0] od2;
      logic [OD1_W-1:0] od1;
      logic [IN_W-1:0]  indiv;
   } pll_div_t;

   function automatic pll_div_t word_to_div(input logic [WORD_W-1:0] w);
      pll_div_t d;
      d.fb    = w[FB_LSB  +: FB_W];
      d.od2   = w[OD2_LSB +: OD2_W];
      d.od1   = w[OD1_LSB +: OD1_W];
      d.indiv = w[IN_LSB  +: IN_W];
      return d;
   endfunction

   function automatic logic [WORD_W-1:0] make_word(input logic lock, input logic lost,
                                                   input logic pd, input pll_div_t d);
      logic [WORD_W-1:0] w;
      w = '0;
      w[LOCK_BIT]             = lock;
      w[LOST_BIT]             = lost;
      w[PD_BIT]               = pd;
      w[FB_LSB  +: FB_W]      = d.fb;
      w[OD2_LSB +: OD2_W]     = d.od2;
      w[OD1_LSB +: OD1_W]     = d.od1;
      w[IN_LSB  +: IN_W]      = d.indiv;
      return w;
   endfunction
endpackage

// File: rtl/pllc_next.sv
module pllc_next
   import pllc_pkg::*;
(
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   input  pll_div_t          cur_div,
   input  logic              cur_pd,
   input  logic              cur_lost,
   output pll_div_t          nxt_div,
   output logic              nxt_pd,
   output logic              nxt_lost,
   output logic              restart
);
   pll_div_t w_div;
   logic     w_pd;
   logic     unused_bits;

   assign w_div       = word_to_div(wr_data);
   assign w_pd        = wr_data[PD_BIT];
   assign unused_bits = ^{wr_data[LOCK_BIT], wr_data[29:28], wr_data[11], wr_data[7:6]};

   always_comb begin
      nxt_div  = cur_div;
      nxt_pd   = cur_pd;
      nxt_lost = cur_lost;
      restart  = 1'b0;
      if (wr_en) begin
         nxt_div = w_div;
         nxt_pd  = w_pd;
         if (w_pd) begin
            nxt_lost = 1'b1;
            restart  = 1'b1;
         end else begin
            if (wr_data[LOST_BIT]) nxt_lost = 1'b0;
            // leaving power-down or retuning both restart the settle count
            restart = cur_pd | (w_div != cur_div);
         end
      end
   end
endmodule

// File: rtl/pllc_lock_timer.sv
module pllc_lock_timer #(
   parameter int unsigned LOCK_CYCLES = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold,
   output logic locked
);
   generate
      if (LOCK_CYCLES == 0) begin : g_instant
         always_ff @(posedge clk) begin
            if (!rst_n) locked <= 1'b1;
            else        locked <= ~hold;
         end
      end else begin : g_count
         localparam int CNT_W = (LOCK_CYCLES > 1) ? $clog2(LOCK_CYCLES) : 1;
         localparam logic [CNT_W-1:0] LAST = CNT_W'(LOCK_CYCLES - 1);
         logic [CNT_W-1:0] cnt;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cnt    <= '0;
               locked <= 1'b1;
            end else if (hold) begin
               cnt    <= '0;
               locked <= 1'b0;
            end else if (!locked) begin
               if (cnt == LAST) locked <= 1'b1;
               else             cnt    <= cnt + 1'b1;
            end
         end

         assert_lock_after_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(locked) |-> $past(cnt == LAST));
         assert_hold_blocks_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(locked) |-> $past(!hold));
      end
   endgenerate
endmodule

// File: rtl/pll_ctrl_reg.sv
module pll_ctrl_reg
   import pllc_pkg::*;
#(
   parameter int unsigned       LOCK_CYCLES = 64,
   parameter logic [WORD_W-1:0] RESET_VAL   = 32'h0030_2102
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   output logic [WORD_W-1:0] rd_data,
   output logic              lock_o,
   output logic              pwrdn_o,
   output logic [FB_W-1:0]   fb_div_o,
   output logic [OD2_W-1:0]  out_div2_o,
   output logic [OD1_W-1:0]  out_div1_o,
   output logic [IN_W-1:0]   in_div_o
);
   localparam pll_div_t RST_DIV  = word_to_div(RESET_VAL);
   localparam logic     RST_LOST = RESET_VAL[LOST_BIT];

   generate
      if (RESET_VAL[PD_BIT]) begin : g_bad_reset
         $error("RESET_VAL must leave power-down clear so the PLL starts locked");
      end
   endgenerate

   pll_div_t div_q, nxt_div;
   logic     pd_q, nxt_pd;
   logic     lost_q, nxt_lost;
   logic     restart;
   logic     lock;

   pllc_next u_next (
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .cur_div  (div_q),
      .cur_pd   (pd_q),
      .cur_lost (lost_q),
      .nxt_div  (nxt_div),
      .nxt_pd   (nxt_pd),
      .nxt_lost (nxt_lost),
      .restart  (restart)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div_q  <= RST_DIV;
         pd_q   <= 1'b0;
         lost_q <= RST_LOST;
      end else begin
         div_q  <= nxt_div;
         pd_q   <= nxt_pd;
         lost_q <= nxt_lost;
      end
   end

   pllc_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .hold   (restart | pd_q),
      .locked (lock)
   );

   assign lock_o     = lock;
   assign pwrdn_o    = pd_q;
   assign fb_div_o   = div_q.fb;
   assign out_div2_o = div_q.od2;
   assign out_div1_o = div_q.od1;
   assign in_div_o   = div_q.indiv;
   assign rd_data    = make_word(lock, lost_q, pd_q, div_q);

   assert_pd_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[PD_BIT]) |=> (lost_q && !lock_o));
   assert_pd_keeps_unlocked_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pd_q |-> !lock_o);
   assert_lost_rise_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lost_q) |-> $past(wr_en && wr_data[PD_BIT]));
   assert_lost_clear_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lost_q) |-> $past(wr_en && wr_data[LOST_BIT] && !wr_data[PD_BIT]));
   assert_retune_unlocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_data[PD_BIT] && (word_to_div(wr_data) != div_q)) |=> !lock_o);
   assert_lock_needs_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_o) |-> $past(!pd_q));
endmodule

// File: tb/sim_pll_ctrl_reg.sv
`timescale 1ns/1ps
module sim_pll_ctrl_reg;
   localparam int unsigned N = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        lock_o, pwrdn_o;
   logic [11:0] fb_div_o;
   logic [2:0]  out_div2_o, out_div1_o;
   logic [5:0]  in_div_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   pll_ctrl_reg #(.LOCK_CYCLES(N), .RESET_VAL(32'h0030_2102)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .lock_o(lock_o), .pwrdn_o(pwrdn_o),
      .fb_div_o(fb_div_o), .out_div2_o(out_div2_o), .out_div1_o(out_div1_o),
      .in_div_o(in_div_o)
   );

   function automatic logic [31:0] w(input logic lk, input logic lost, input logic [11:0] fb,
                                     input logic [2:0] od2, input logic pd,
                                     input logic [2:0] od1, input logic [5:0] idv);
      return (32'(lk) << 31) | (32'(lost) << 30) | (32'(fb) << 16) | (32'(od2) << 13)
           | (32'(pd) << 12) | (32'(od1) << 8) | 32'(idv);
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // called at a falling edge; returns one falling edge after the write edge
   task automatic wr(input logic [31:0] d);
      wr_en = 1'b1;
      wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      wr_data = '0;
   endtask

   task automatic finish_up;
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_up();
   end

   initial begin
      logic [31:0] base;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state, R9 outputs
      check("R1 reset word", rd_data, 32'h8030_2102);
      check("R1 reset lock", 32'(lock_o), 32'd1);
      check("R9 reset dividers", {fb_div_o, 1'b0, out_div2_o, out_div1_o, in_div_o, pwrdn_o},
            {12'h030, 1'b0, 3'd1, 3'd1, 6'd2, 1'b0});

      // R6 / R8: same dividers with bit 31 written 0 keeps lock
      wr(32'h0030_2102);
      check("R6 same-value write keeps lock", 32'(lock_o), 32'd1);
      repeat (3) @(negedge clk);
      check("R8 write 0 to lock bit ignored", rd_data, 32'h8030_2102);

      // R2 / R9 sweep of input divider, reserved bits written 1
      for (int i = 0; i < 64; i++) begin
         wr(w(1'b0, 1'b0, 12'h030, 3'd1, 1'b0, 3'd1, 6'(i)) | 32'h3000_08C0);
         check("R2 input divider sweep", rd_data, w(1'b0, 1'b0, 12'h030, 3'd1, 1'b0, 3'd1, 6'(i)));
         check("R9 in_div_o", 32'(in_div_o), 32'(i));
      end
      // R2 sweep of both output dividers
      for (int a = 0; a < 8; a++) begin
         for (int b = 0; b < 8; b++) begin
            wr(w(1'b0, 1'b0, 12'h030, 3'(a), 1'b0, 3'(b), 6'd63));
            check("R2 output divider sweep", rd_data, w(1'b0, 1'b0, 12'h030, 3'(a), 1'b0, 3'(b), 6'd63));
            check("R9 out dividers", {29'd0, out_div2_o} * 8 + 32'(out_div1_o), 32'(a * 8 + b));
         end
      end
      // R2 walking one over the feedback divider, then all ones
      for (int k = 0; k <= 12; k++) begin
         logic [11:0] fb;
         fb = (k == 12) ? 12'hFFF : 12'(1 << k);
         wr(w(1'b0, 1'b0, fb, 3'd7, 1'b0, 3'd7, 6'd1));
         check("R2 feedback divider sweep", rd_data, w(1'b0, 1'b0, fb, 3'd7, 1'b0, 3'd7, 6'd1));
         check("R9 fb_div_o", 32'(fb_div_o), 32'(fb));
      end

      // R5 retune restarts lock, no loss flag
      base = w(1'b0, 1'b0, 12'h040, 3'd2, 1'b0, 3'd1, 6'd1);
      wr(base);
      repeat (N) @(negedge clk);
      check("R5 settled before retune", 32'(lock_o), 32'd1);
      wr(w(1'b0, 1'b0, 12'h041, 3'd2, 1'b0, 3'd1, 6'd1));
      check("R5 retune drops lock, lost stays 0", rd_data[31:30], 2'b00);
      repeat (N - 1) @(negedge clk);
      check("R5 lock still low at edge N-1", 32'(lock_o), 32'd0);
      @(negedge clk);
      check("R5 lock high at edge N", 32'(lock_o), 32'd1);
      base = w(1'b0, 1'b0, 12'h041, 3'd2, 1'b0, 3'd1, 6'd1);

      // R3 power-down
      wr(base | 32'h0000_1000);
      check("R3 pd word", rd_data, base | 32'h4000_1000);
      check("R3 pwrdn_o", 32'(pwrdn_o), 32'd1);
      repeat (20) @(negedge clk);
      check("R3 lock stays low in pd", 32'(lock_o), 32'd0);
      // R7: clear attempt while powered down has no effect
      wr(base | 32'h4000_1000);
      check("R7 lost kept under pd", rd_data, base | 32'h4000_1000);

      // R4 release
      wr(base);
      check("R4 release: lost kept, lock low", rd_data, base | 32'h4000_0000);
      repeat (N - 1) @(negedge clk);
      check("R4 lock still low at edge N-1", 32'(lock_o), 32'd0);
      @(negedge clk);
      check("R4 lock high at edge N", rd_data, base | 32'hC000_0000);

      // R7 write 0 keeps, write 1 clears, lock undisturbed
      wr(base);
      check("R7 write 0 keeps lost", rd_data, base | 32'hC000_0000);
      wr(base | 32'h4000_0000);
      check("R7 write 1 clears lost", rd_data, base | 32'h8000_0000);

      // R8 / R6: writing lock bit 1 mid-count does not force or restart lock
      wr(base | 32'h0000_1000);
      wr(base);
      wr(base | 32'h8000_0000);
      check("R8 lock bit write ignored", 32'(lock_o), 32'd0);
      repeat (N - 2) @(negedge clk);
      check("R6 count not restarted, low at N-1", 32'(lock_o), 32'd0);
      @(negedge clk);
      check("R6 count not restarted, high at N", 32'(lock_o), 32'd1);

      finish_up();
   end
endmodule